// File: doc/BRIEF.md
# Flat Region Wide Smoothing Filter

This block applies the long low-pass smoothing used by a video deblocking stage across a block edge. One edge row of sixteen pixels arrives in parallel: seven on the near side beyond the nearest one (p7 down to p1), the two pixels touching the edge (p0 and q0), and seven more on the far side (q1 up to q7). A mode input selects which smoothing to apply. The eight-tap mode replaces the three pixels nearest the edge on each side. The sixteen-tap mode replaces the seven pixels nearest the edge on each side. Every pixel the mode does not cover leaves the block unchanged.

Each smoothed pixel is a rounded average over a window centred on it, with the centre pixel counted twice. A window that runs past the outermost tap of the mode repeats that outermost pixel. The first window of each mode is summed in full. Each later window comes from the one before it: the pair of taps that leaves is subtracted and the pair that enters is added. The decision on where smoothing applies, and the short edge filter, are made upstream. This block is used after that decision, once per row. The result is registered and comes out one cycle after its input.

Top module: `flat_smooth_filter`

## Requirements
- R1: `out_valid` is low after reset, and in every cycle it equals the value `in_valid` had one clock earlier. After reset `out_pix` is zero.
- R2: With `in_mode` 0 (off) or 1 (narrow), the `out_pix` registered from a valid input equals that `in_pix` bit for bit.
- R3: In mode 2 (eight-tap), new p2 = (3*p3 + 2*p2 + p1 + p0 + q0 + 4) >> 3. Pixel i occupies `in_pix[8*i +: 8]`, with i = 0 for p7, i = 7 for p0, i = 8 for q0 and i = 15 for q7.
- R4: In mode 2, new p1, p0, q0, q1 and q2 each equal (sum of the seven taps centred on that pixel + the centre pixel + 4) >> 3. Any tap beyond p3 reads as p3, and any tap beyond q3 reads as q3.
- R5: In mode 2, positions p7..p3 and q3..q7 are output unchanged.
- R6: In mode 3 (sixteen-tap), new p6 = (7*p7 + 2*p6 + p5 + p4 + p3 + p2 + p1 + p0 + q0 + 8) >> 4.
- R7: In mode 3, new p5 through q6 each equal (sum of the fifteen taps centred on that pixel + the centre pixel + 8) >> 4. Any tap beyond p7 reads as p7, and any tap beyond q7 reads as q7.
- R8: In mode 3, p7 and q7 are output unchanged.
- R9: Window sums up to sixteen taps of 255 do not overflow: an input row of all 255 gives all 255 in every mode.
- R10: While `in_valid` is low, `out_pix` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input row is valid this cycle |
| in_mode | input | 2 | 0 off, 1 narrow, 2 eight-tap, 3 sixteen-tap |
| in_pix | input | 128 | Sixteen 8-bit pixels, p7 in the low byte, q7 in the high byte |
| out_valid | output | 1 | Registered copy of in_valid |
| out_pix | output | 128 | Smoothed row, registered, same layout as in_pix |

## Verification
Every input row is tried in all four modes. The rows are pseudo-random to exercise general rounding, small-spread values around a base level to match the flat regions this filter serves, and ramps and steps whose large gradient near the edge exposes a wrong tap or a misplaced padding pixel. All-zero and all-255 rows bound the rounding and the accumulator width. The bench compares each output byte with a direct window sum. Because of that, an error in the sliding update shows up at the exact pixel where it enters the chain, and an off-by-one window bound shows up only at the outermost written pixels. A run with `in_valid` low and changed pixels separates holding the output from tracking the input.

// File: rtl/lpf_smooth_pkg.sv
package lpf_smooth_pkg;

    localparam int PIX_W  = 8;
    localparam int NPIX   = 16;
    localparam int ACC_W  = 12;
    localparam int MODE_W = 2;
    localparam int ROW_W  = NPIX * PIX_W;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF    = 2'd0,
        MODE_NARROW = 2'd1,
        MODE_WIDE8  = 2'd2,
        MODE_WIDE16 = 2'd3
    } smooth_mode_e;

    typedef logic [ROW_W-1:0] pix_row_t;
    typedef logic [ACC_W-1:0] acc_t;

    // Read pixel idx, replicating the edge taps lo/hi outside [lo,hi].
    function automatic logic [PIX_W-1:0] pick_tap(pix_row_t row, int idx, int lo, int hi);
        int c;
        if (idx < lo)      c = lo;
        else if (idx > hi) c = hi;
        else               c = idx;
        return row[c*PIX_W +: PIX_W];
    endfunction

    function automatic acc_t widen(logic [PIX_W-1:0] x);
        return {{(ACC_W-PIX_W){1'b0}}, x};
    endfunction

    function automatic logic [PIX_W-1:0] round_shift(acc_t acc, int sh);
        acc_t t;
        t = acc + (acc_t'(1) << (sh - 1));
        t = t >> sh;
        return t[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/lpf_window_chain.sv
module lpf_window_chain
    import lpf_smooth_pkg::*;
#(
    parameter int LO    = 4,
    parameter int HI    = 11,
    parameter int HALF  = 3,
    parameter int SHIFT = 3
) (
    input  pix_row_t pix,
    output pix_row_t res
);
    localparam int NOUT  = HI - LO - 1;
    localparam int FIRST = LO + 1;

    acc_t acc [NOUT];
    acc_t acc_init;

    // Full sum of the first window, centre counted twice.
    always_comb begin
        acc_t s;
        s = widen(pick_tap(pix, FIRST, LO, HI));
        for (int j = FIRST - HALF; j <= FIRST + HALF; j++) begin
            s = s + widen(pick_tap(pix, j, LO, HI));
        end
        acc_init = s;
    end

    // Slide: drop far-left tap and old centre, add new centre and far-right tap.
    for (genvar m = 0; m < NOUT; m++) begin : g_slide
        if (m == 0) begin : g_head
            assign acc[m] = acc_init;
        end else begin : g_step
            localparam int KP = LO + m;
            assign acc[m] = acc[m-1]
                          + widen(pick_tap(pix, KP + 1, LO, HI))
                          + widen(pick_tap(pix, KP + 1 + HALF, LO, HI))
                          - widen(pick_tap(pix, KP - HALF, LO, HI))
                          - widen(pick_tap(pix, KP, LO, HI));
        end
    end

    for (genvar i = 0; i < NPIX; i++) begin : g_out
        if (i > LO && i < HI) begin : g_filt
            assign res[i*PIX_W +: PIX_W] = round_shift(acc[i-FIRST], SHIFT);
        end else begin : g_pass
            assign res[i*PIX_W +: PIX_W] = pix[i*PIX_W +: PIX_W];
        end
    end

endmodule

// File: rtl/lpf_out_stage.sv
module lpf_out_stage
    import lpf_smooth_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  smooth_mode_e     mode,
    input  pix_row_t         raw,
    input  pix_row_t         wide8,
    input  pix_row_t         wide16,
    output logic             out_valid,
    output pix_row_t         out_pix
);
    pix_row_t sel;

    always_comb begin
        case (mode)
            MODE_WIDE8:  sel = wide8;
            MODE_WIDE16: sel = wide16;
            default:     sel = raw;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_pix <= sel;
        end
    end

endmodule

// File: rtl/flat_smooth_filter.sv
module flat_smooth_filter
    import lpf_smooth_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [MODE_W-1:0]    in_mode,
    input  logic [ROW_W-1:0]     in_pix,
    output logic                 out_valid,
    output logic [ROW_W-1:0]     out_pix
);
    localparam int CTR = NPIX / 2;

    pix_row_t row8;
    pix_row_t row16;

    lpf_window_chain #(.LO(CTR-4), .HI(CTR+3), .HALF(3), .SHIFT(3)) u_chain8 (
        .pix (in_pix),
        .res (row8)
    );

    lpf_window_chain #(.LO(0), .HI(NPIX-1), .HALF(7), .SHIFT(4)) u_chain16 (
        .pix (in_pix),
        .res (row16)
    );

    lpf_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .mode      (smooth_mode_e'(in_mode)),
        .raw       (in_pix),
        .wide8     (row8),
        .wide16    (row16),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

endmodule

// File: rtl/flat_smooth_filter_chk.sv
module flat_smooth_filter_chk
    import lpf_smooth_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [MODE_W-1:0]    in_mode,
    input  logic [ROW_W-1:0]     in_pix,
    input  logic                 out_valid,
    input  logic [ROW_W-1:0]     out_pix
);
    logic [11:0] cf8;
    logic [11:0] cf16;

    assign cf8 = 12'(3*int'(in_pix[39:32]) + 2*int'(in_pix[47:40]) + int'(in_pix[55:48])
                   + int'(in_pix[63:56]) + int'(in_pix[71:64]) + 4);

    always_comb begin
        int s;
        s = 7*int'(in_pix[7:0]) + 2*int'(in_pix[15:8]) + 8;
        for (int i = 2; i <= 8; i++) s = s + int'(in_pix[i*8 +: 8]);
        cf16 = 12'(s);
    end

    assert_valid_rise_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_fall_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode[1] == 1'b0) |=> out_pix == $past(in_pix));
    assert_first8_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'd2) |=> out_pix[47:40] == $past(cf8[10:3]));
    assert_outer8_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'd2) |=>
        (out_pix[39:0] == $past(in_pix[39:0]) && out_pix[127:88] == $past(in_pix[127:88])));
    assert_first16_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'd3) |=> out_pix[15:8] == $past(cf16[11:4]));
    assert_outer16_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'd3) |=>
        (out_pix[7:0] == $past(in_pix[7:0]) && out_pix[127:120] == $past(in_pix[127:120])));
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_pix));

endmodule

bind flat_smooth_filter flat_smooth_filter_chk u_chk (.*);

// File: tb/flat_smooth_filter_tb.sv
module flat_smooth_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   in_mode = 2'd0;
    logic [127:0] in_pix = '0;
    logic         out_valid;
    logic [127:0] out_pix;

    int n_cmp  = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    flat_smooth_filter u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_pix(in_pix), .out_valid(out_valid), .out_pix(out_pix)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    function automatic int px(logic [127:0] v, int i);
        return int'(v[i*8 +: 8]);
    endfunction

    // Direct window average, independent of any sliding update.
    function automatic int ref_pix(logic [127:0] v, int mode, int k);
        int lo, hi, h, sh, s, c;
        if (mode == 2 && k >= 5 && k <= 10) begin
            lo = 4; hi = 11; h = 3; sh = 3;
        end else if (mode == 3 && k >= 1 && k <= 14) begin
            lo = 0; hi = 15; h = 7; sh = 4;
        end else begin
            return px(v, k);
        end
        s = px(v, k);
        for (int j = k - h; j <= k + h; j++) begin
            c = (j < lo) ? lo : ((j > hi) ? hi : j);
            s = s + px(v, c);
        end
        return (s + (1 << (sh - 1))) >> sh;
    endfunction

    function automatic string req_of(int mode, int k);
        if (mode < 2) return "R2";
        if (mode == 2) begin
            if (k == 5) return "R3";
            if (k > 5 && k <= 10) return "R4";
            return "R5";
        end
        if (k == 1) return "R6";
        if (k > 1 && k <= 14) return "R7";
        return "R8";
    endfunction

    task automatic check_eq(string req, string what, int act, int exp);
        n_cmp = n_cmp + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_row(logic [127:0] v, int mode, string tag_override);
        in_valid = 1'b1;
        in_mode  = 2'(mode);
        in_pix   = v;
        @(negedge clk);
        check_eq("R1", "out_valid", int'(out_valid), 1);
        for (int k = 0; k < 16; k++) begin
            string r;
            r = (tag_override.len() > 0) ? tag_override : req_of(mode, k);
            check_eq(r, $sformatf("mode %0d pixel %0d", mode, k), px(out_pix, k), ref_pix(v, mode, k));
        end
    endtask

    function automatic logic [31:0] step_lcg(logic [31:0] x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    initial begin
        logic [127:0] v;
        logic [127:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1", "out_valid after reset", int'(out_valid), 0);
        check_eq("R1", "out_pix after reset", int'(out_pix != 0), 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "out_valid idle", int'(out_valid), 0);

        // R9: all-255 and all-zero bounds
        for (int m = 0; m < 4; m++) begin
            run_row({16{8'hFF}}, m, "R9");
            run_row('0, m, "");
        end

        // Pseudo-random rows
        for (int n = 0; n < 150; n++) begin
            for (int i = 0; i < 4; i++) begin
                lcg = step_lcg(lcg);
                v[i*32 +: 32] = lcg;
            end
            for (int m = 0; m < 4; m++) run_row(v, m, "");
        end

        // Flat-ish rows: base level with small spread
        for (int b = 0; b < 256; b += 17) begin
            for (int i = 0; i < 16; i++) begin
                lcg = step_lcg(lcg);
                v[i*8 +: 8] = 8'((b + int'(lcg[27:25])) > 255 ? 255 : (b + int'(lcg[27:25])));
            end
            for (int m = 0; m < 4; m++) run_row(v, m, "");
        end

        // Ramps and steps across the edge
        for (int s = 1; s < 17; s++) begin
            for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(i * s);
            for (int m = 0; m < 4; m++) run_row(v, m, "");
            for (int i = 0; i < 16; i++) v[i*8 +: 8] = (i < 8) ? 8'(s * 3) : 8'(255 - s * 5);
            for (int m = 0; m < 4; m++) run_row(v, m, "");
        end

        // R10: hold while in_valid low
        held = out_pix;
        in_valid = 1'b0;
        in_mode  = 2'd3;
        in_pix   = {16{8'h5A}};
        @(negedge clk);
        check_eq("R10", "out_pix held", int'(out_pix != held), 0);
        check_eq("R1", "out_valid low", int'(out_valid), 0);
        in_pix = {16{8'hA5}};
        @(negedge clk);
        check_eq("R10", "out_pix still held", int'(out_pix != held), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule